// File: doc/BRIEF.md
# Timer Status Flags and Software Event Generation

This block keeps the interrupt status flags of a small general-purpose timer with a single capture/compare channel, and turns software writes into one-cycle event strobes. The counter core feeds it qualified moments: a compare match, overflow, underflow, a capture edge, a trigger reinitialisation, and whether the repetition counter has reached zero. The block qualifies each of these against the control bits. These are update disable, update request source, channel direction, and whether the compare value lies above the auto-reload value. From that it sets the update, capture/compare, commutation, trigger and break flags.

Software reaches the block through a simple register port. An interrupt-enable register is read/write. The status register is cleared by writing zero to a bit. The event register is write-only and self-clearing. The capture register holds the counter value taken on each capture, and reading it in input mode clears the capture/compare flag. A break event clears the main output enable. The interrupt request is the OR of every flag that has its enable bit set.

Top module: `tmr_flags_evt`

## Requirements
- R1: After reset, the status flags, interrupt enables, capture register and main output enable are all zero, and irq is 0.
- R2: A write to the event register (offset 0x14) drives a one-cycle strobe in the following cycle for each written 1 in bit positions 0 (update), 1 (capture/compare), 5 (commutation), 6 (trigger) and 7 (break). Written zeros produce no strobe, and a read of offset 0x14 returns 0.
- R3: The update flag (status bit 0) is set on overflow or underflow only when rep_zero is 1 and upd_dis is 0.
- R4: The update flag is set by an update-event write or a trigger reinitialisation only when both upd_req_src and upd_dis are 0.
- R5: In output mode, the capture/compare flag (status bit 1) is set on a compare match. When cmp_above_reload is 1, it is instead set on overflow when counting up and on underflow when counting down, and a match is ignored.
- R6: In input mode, a capture edge sets the capture/compare flag and loads cnt_val into the capture register (offset 0x34). Reading that register clears the flag.
- R7: A capture/compare event write always sets the capture/compare flag. In input mode it also loads cnt_val into the capture register.
- R8: A commutation event write sets status bit 5, and a trigger event write sets status bit 6.
- R9: A break event write sets status bit 7 and clears main_out_en. moe_set sets main_out_en, but break wins over it.
- R10: Writing the status register (offset 0x10) clears each flag written as 0 and leaves each flag written as 1 unchanged. A hardware set in the same cycle wins over the clear.
- R11: irq is 1 exactly when some flag and its enable bit at the same position in the enable register (offset 0x0C) are both 1.
- R12: Status bits 4:2 and 15:8 read as 0 and cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_match | input | 1 | Counter equals compare value |
| cnt_ovf | input | 1 | Counter overflow |
| cnt_unf | input | 1 | Counter underflow |
| cnt_down | input | 1 | Counter counts down |
| cmp_above_reload | input | 1 | Compare value exceeds auto-reload |
| cap_edge | input | 1 | Qualified capture input edge |
| trg_reinit | input | 1 | Counter reinitialised by trigger |
| rep_zero | input | 1 | Repetition counter is zero |
| cnt_val | input | CNT_W | Current counter value |
| upd_dis | input | 1 | Update disable |
| upd_req_src | input | 1 | Update request source restricted to overflow/underflow |
| ch_input | input | 1 | Channel configured as input |
| moe_set | input | 1 | Set main output enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data |
| stat_flags | output | DW | Status flag levels |
| ev_update | output | 1 | Update event strobe |
| ev_capcmp | output | 1 | Capture/compare event strobe |
| ev_commut | output | 1 | Commutation event strobe |
| ev_trig | output | 1 | Trigger event strobe |
| ev_break | output | 1 | Break event strobe |
| main_out_en | output | 1 | Main output enable |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. Event strobes last a single cycle. Update disable keeps the update flag from rising. Break removes the output enable. A capture edge in input mode always raises the capture/compare flag. The request line only rises with some flag set. Other behaviour needs the directed scenarios: the exact qualification of the update sources by repetition zero and request source, and the overflow or underflow fallback above auto-reload. They also cover the captured counter value, clear-on-read, and write-zero-to-clear racing a hardware set.

// File: rtl/tmr_flags_pkg.sv
package tmr_flags_pkg;
    localparam int BIT_UPD = 0;
    localparam int BIT_CC  = 1;
    localparam int BIT_COM = 5;
    localparam int BIT_TRG = 6;
    localparam int BIT_BRK = 7;
    localparam int FLAG_W  = 8;
    localparam logic [FLAG_W-1:0] FLAG_MASK = FLAG_W'((1 << BIT_UPD) | (1 << BIT_CC) |
                                                      (1 << BIT_COM) | (1 << BIT_TRG) |
                                                      (1 << BIT_BRK));
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_EVT  = 8'h14;
    localparam logic [7:0] OFS_CAP  = 8'h34;
endpackage

// File: rtl/tmr_upd_qual.sv
module tmr_upd_qual (
    input  logic ovf_any,
    input  logic rep_zero,
    input  logic ug_evt,
    input  logic trg_reinit,
    input  logic upd_dis,
    input  logic upd_req_src,
    output logic upd_set
);
    logic from_wrap;
    logic from_reinit;

    always_comb begin
        from_wrap   = ovf_any && rep_zero && !upd_dis;
        from_reinit = (ug_evt || trg_reinit) && !upd_req_src && !upd_dis;
        upd_set     = from_wrap || from_reinit;
    end
endmodule

// File: rtl/tmr_cc_qual.sv
module tmr_cc_qual (
    input  logic ch_input,
    input  logic cnt_match,
    input  logic cnt_ovf,
    input  logic cnt_unf,
    input  logic cnt_down,
    input  logic cmp_above_reload,
    input  logic cap_edge,
    input  logic ccg_evt,
    output logic cc_set,
    output logic cap_strobe
);
    logic wrap_hit;
    logic out_hit;

    always_comb begin
        wrap_hit   = cnt_down ? cnt_unf : cnt_ovf;
        out_hit    = cmp_above_reload ? wrap_hit : cnt_match;
        cap_strobe = ch_input && (cap_edge || ccg_evt);
        cc_set     = ccg_evt || (ch_input ? cap_edge : out_hit);
    end
endmodule

// File: rtl/tmr_flags_evt.sv
module tmr_flags_evt
    import tmr_flags_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DW     = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_match,
    input  logic              cnt_ovf,
    input  logic              cnt_unf,
    input  logic              cnt_down,
    input  logic              cmp_above_reload,
    input  logic              cap_edge,
    input  logic              trg_reinit,
    input  logic              rep_zero,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              upd_dis,
    input  logic              upd_req_src,
    input  logic              ch_input,
    input  logic              moe_set,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     stat_flags,
    output logic              ev_update,
    output logic              ev_capcmp,
    output logic              ev_commut,
    output logic              ev_trig,
    output logic              ev_break,
    output logic              main_out_en,
    output logic              irq
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] ien;
        logic [FLAG_W-1:0] evt;
        logic [CNT_W-1:0]  cap;
        logic              moe;
    } state_t;

    state_t st_d, st_q;

    logic              upd_set, cc_set, cap_strobe;
    logic              hit_ien, hit_stat, hit_evt, hit_cap;
    logic [FLAG_W-1:0] hw_set, sw_clr, wdata_lo;

    assign hit_ien  = bus_addr == ADDR_W'(OFS_IEN);
    assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
    assign hit_evt  = bus_addr == ADDR_W'(OFS_EVT);
    assign hit_cap  = bus_addr == ADDR_W'(OFS_CAP);
    assign wdata_lo = bus_wdata[FLAG_W-1:0];

    tmr_upd_qual u_upd (
        .ovf_any     (cnt_ovf || cnt_unf),
        .rep_zero    (rep_zero),
        .ug_evt      (st_q.evt[BIT_UPD]),
        .trg_reinit  (trg_reinit),
        .upd_dis     (upd_dis),
        .upd_req_src (upd_req_src),
        .upd_set     (upd_set)
    );

    tmr_cc_qual u_cc (
        .ch_input         (ch_input),
        .cnt_match        (cnt_match),
        .cnt_ovf          (cnt_ovf),
        .cnt_unf          (cnt_unf),
        .cnt_down         (cnt_down),
        .cmp_above_reload (cmp_above_reload),
        .cap_edge         (cap_edge),
        .ccg_evt          (st_q.evt[BIT_CC]),
        .cc_set           (cc_set),
        .cap_strobe       (cap_strobe)
    );

    always_comb begin
        st_d = st_q;

        hw_set          = '0;
        hw_set[BIT_UPD] = upd_set;
        hw_set[BIT_CC]  = cc_set;
        hw_set[BIT_COM] = st_q.evt[BIT_COM];
        hw_set[BIT_TRG] = st_q.evt[BIT_TRG];
        hw_set[BIT_BRK] = st_q.evt[BIT_BRK];

        sw_clr = '0;
        if (bus_wr && hit_stat) sw_clr = ~wdata_lo & FLAG_MASK;
        if (bus_rd && hit_cap && ch_input) sw_clr[BIT_CC] = 1'b1;

        st_d.flags = ((st_q.flags & ~sw_clr) | hw_set) & FLAG_MASK;
        st_d.evt   = (bus_wr && hit_evt) ? (wdata_lo & FLAG_MASK) : '0;
        if (bus_wr && hit_ien) st_d.ien = wdata_lo & FLAG_MASK;
        if (cap_strobe) st_d.cap = cnt_val;
        if (moe_set) st_d.moe = 1'b1;
        if (st_q.evt[BIT_BRK]) st_d.moe = 1'b0;

        bus_rdata = '0;
        if (hit_ien)  bus_rdata = DW'(st_q.ien);
        if (hit_stat) bus_rdata = DW'(st_q.flags);
        if (hit_cap)  bus_rdata = DW'(st_q.cap);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_flags  = DW'(st_q.flags);
    assign ev_update   = st_q.evt[BIT_UPD];
    assign ev_capcmp   = st_q.evt[BIT_CC];
    assign ev_commut   = st_q.evt[BIT_COM];
    assign ev_trig     = st_q.evt[BIT_TRG];
    assign ev_break    = st_q.evt[BIT_BRK];
    assign main_out_en = st_q.moe;
    assign irq         = |(st_q.flags & st_q.ien);
endmodule

// File: rtl/tmr_flags_evt_chk.sv
module tmr_flags_evt_chk
    import tmr_flags_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_ovf,
    input logic              cnt_down,
    input logic              cmp_above_reload,
    input logic              cap_edge,
    input logic              ch_input,
    input logic              upd_dis,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     stat_flags,
    input logic              ev_break,
    input logic              ev_update,
    input logic              main_out_en,
    input logic              irq
);
    logic evt_wr;
    assign evt_wr = bus_wr && (bus_addr == ADDR_W'(OFS_EVT));

    p_evt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_update && !(evt_wr && bus_wdata[BIT_UPD]) |=> !ev_update);

    p_upd_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dis && !stat_flags[BIT_UPD] |=> !stat_flags[BIT_UPD]);

    p_wrap_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_input && cmp_above_reload && !cnt_down && cnt_ovf |=> stat_flags[BIT_CC]);

    p_capture_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_input && cap_edge |=> stat_flags[BIT_CC]);

    p_break_moe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_break |=> !main_out_en && stat_flags[BIT_BRK]);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_flags != '0));

    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flags & ~DW'(FLAG_MASK)) == '0);
endmodule

bind tmr_flags_evt tmr_flags_evt_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_ovf(cnt_ovf), .cnt_down(cnt_down),
    .cmp_above_reload(cmp_above_reload), .cap_edge(cap_edge), .ch_input(ch_input),
    .upd_dis(upd_dis), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stat_flags(stat_flags), .ev_break(ev_break), .ev_update(ev_update),
    .main_out_en(main_out_en), .irq(irq)
);

// File: tb/tmr_flags_evt_test.sv
module tmr_flags_evt_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_match = 0, cnt_ovf = 0, cnt_unf = 0, cnt_down = 0, cmp_above_reload = 0;
    logic cap_edge = 0, trg_reinit = 0, rep_zero = 0, upd_dis = 0, upd_req_src = 0;
    logic ch_input = 0, moe_set = 0, bus_wr = 0, bus_rd = 0;
    logic [15:0] cnt_val = '0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, stat_flags;
    logic ev_update, ev_capcmp, ev_commut, ev_trig, ev_break, main_out_en, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tmr_flags_evt uut (.*);

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic clear_all();
        wr(8'h10, 16'h0000);
        tick();
    endtask

    task automatic t_reset();
        chk(stat_flags, 16'h0, "R1 flags");
        chk({15'd0, main_out_en}, 16'h0, "R1 moe");
        chk({15'd0, irq}, 16'h0, "R1 irq");
        bus_addr = 8'h34; #1 chk(bus_rdata, 16'h0, "R1 capture");
        bus_addr = 8'h0C; #1 chk(bus_rdata, 16'h0, "R1 enables");
    endtask

    task automatic t_events();
        bus_wr = 1; bus_addr = 8'h14; bus_wdata = 16'h00E3;
        #1 chk(bus_rdata, 16'h0, "R2 event reads zero");
        tick(); bus_wr = 0;
        chk({11'd0, ev_break, ev_trig, ev_commut, ev_capcmp, ev_update}, 16'h001F, "R2 strobes");
        tick();
        chk({11'd0, ev_break, ev_trig, ev_commut, ev_capcmp, ev_update}, 16'h0, "R2 self clear");
        chk(stat_flags, 16'h00E3, "R8 R9 flags from events");
        clear_all();
        wr(8'h14, 16'h0040);
        chk({11'd0, ev_break, ev_trig, ev_commut, ev_capcmp, ev_update}, 16'h0008, "R2 zero bits no strobe");
        tick();
        chk(stat_flags, 16'h0040, "R8 trigger only");
        clear_all();
    endtask

    task automatic t_update();
        cnt_ovf = 1; rep_zero = 0; tick(); cnt_ovf = 0;
        chk(stat_flags, 16'h0, "R3 rep not zero");
        cnt_ovf = 1; rep_zero = 1; upd_dis = 1; tick(); cnt_ovf = 0;
        chk(stat_flags, 16'h0, "R3 udis blocks");
        upd_dis = 0; cnt_unf = 1; tick(); cnt_unf = 0; rep_zero = 0;
        chk(stat_flags, 16'h0001, "R3 underflow sets");
        clear_all();
        upd_req_src = 1; trg_reinit = 1; tick(); trg_reinit = 0;
        wr(8'h14, 16'h0001); tick();
        chk(stat_flags, 16'h0, "R4 URS blocks");
        upd_req_src = 0; trg_reinit = 1; tick(); trg_reinit = 0;
        chk(stat_flags, 16'h0001, "R4 trigger reinit sets");
        clear_all();
        wr(8'h14, 16'h0001); tick();
        chk(stat_flags, 16'h0001, "R4 UG sets");
        clear_all();
    endtask

    task automatic t_compare();
        ch_input = 0; cnt_match = 1; tick(); cnt_match = 0;
        chk(stat_flags, 16'h0002, "R5 match sets");
        clear_all();
        cmp_above_reload = 1; cnt_match = 1; tick(); cnt_match = 0;
        cnt_unf = 1; cnt_down = 0; tick(); cnt_unf = 0;
        chk(stat_flags, 16'h0, "R5 above reload ignores match and underflow up");
        cnt_ovf = 1; tick(); cnt_ovf = 0;
        chk(stat_flags, 16'h0002, "R5 overflow up sets");
        clear_all();
        cnt_down = 1; cnt_unf = 1; tick(); cnt_unf = 0; cnt_down = 0; cmp_above_reload = 0;
        chk(stat_flags, 16'h0002, "R5 underflow down sets");
        clear_all();
    endtask

    task automatic t_capture();
        ch_input = 1; cnt_val = 16'hA5C3; cap_edge = 1; tick(); cap_edge = 0; cnt_val = 16'h0011;
        chk(stat_flags, 16'h0002, "R6 capture sets");
        bus_rd = 1; bus_addr = 8'h34; #1 chk(bus_rdata, 16'hA5C3, "R6 captured value");
        tick(); bus_rd = 0;
        chk(stat_flags, 16'h0, "R6 read clears");
        cnt_val = 16'h7E01;
        wr(8'h14, 16'h0002); tick();
        chk(stat_flags, 16'h0002, "R7 CCG sets in input");
        bus_addr = 8'h34; #1 chk(bus_rdata, 16'h7E01, "R7 CCG captures");
        clear_all();
        ch_input = 0; cnt_val = 16'h3333;
        wr(8'h14, 16'h0002); tick();
        chk(stat_flags, 16'h0002, "R7 CCG sets in output");
        bus_addr = 8'h34; #1 chk(bus_rdata, 16'h7E01, "R7 no capture in output");
        clear_all();
    endtask

    task automatic t_break();
        moe_set = 1; tick(); moe_set = 0;
        chk({15'd0, main_out_en}, 16'h1, "R9 moe set");
        wr(8'h14, 16'h0080);
        moe_set = 1; tick(); moe_set = 0;
        chk({15'd0, main_out_en}, 16'h0, "R9 break clears moe");
        chk(stat_flags, 16'h0080, "R9 break flag");
        clear_all();
    endtask

    task automatic t_clear();
        wr(8'h14, 16'h0060); tick();
        wr(8'h10, 16'hFFDF);
        chk(stat_flags, 16'h0040, "R10 write zero clears one");
        cnt_match = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 16'h0000; tick();
        bus_wr = 0; cnt_match = 0;
        chk(stat_flags, 16'h0002, "R10 set wins over clear");
        wr(8'h10, 16'hFF1C);
        bus_addr = 8'h10; #1 chk(bus_rdata, 16'h0, "R12 reserved read zero");
    endtask

    task automatic t_irq();
        wr(8'h0C, 16'h0040);
        wr(8'h14, 16'h0020); tick();
        chk({15'd0, irq}, 16'h0, "R11 disabled flag no irq");
        wr(8'h14, 16'h0040); tick();
        chk({15'd0, irq}, 16'h1, "R11 enabled flag irq");
        wr(8'h10, 16'hFFBF);
        chk({15'd0, irq}, 16'h0, "R11 irq drops");
        bus_addr = 8'h0C; #1 chk(bus_rdata, 16'h0040, "R11 enable readback");
        clear_all();
    endtask

    initial begin
        tick(); tick();
        rst_n = 1; tick();
        t_reset();
        t_events();
        t_update();
        t_compare();
        t_capture();
        t_break();
        t_clear();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule